// File: doc/BRIEF.md
# Free-running timer base with fast flag clear

This block is the time base of a capture/compare timer. A 16-bit counter steps up by one on each clock while software has enabled it. Two system-mode inputs, wait and freeze, can each stop the count when the matching control bit asks for it. The block holds an overflow flag, set when the counter wraps. It also holds one event flag for each of eight capture/compare channels, each set by a strobe from that channel's datapath outside this block. A 16-bit register per channel stands in for that channel's capture or compare value on the bus.

Software reaches the block over a simple register bus: address, read and write strobes, and a width select for 8- or 16-bit transfers. Read data is combinational in the cycle of the strobe, and any side effect of an access takes place at the clock edge that ends it. Flags normally clear when software writes a 1 to them. With the fast-clear control bit set, ordinary accesses also clear flags. A counter access clears the overflow flag. A read of a capture channel's register, or a write to a compare channel's register, clears that channel's flag.

Top module: `frt_timer`

## Requirements
- R1: The counter increments by one per clock only while control bit 7 (enable) is 1. While enable is 0 the counter holds its value.
- R2: After reset the control register reads 0x00, the counter reads 0x0000 and stays there, and the overflow and channel flag registers read 0x00.
- R3: With control bit 6 at 1, the counter holds while the wait input is high. With bit 6 at 0, the counter keeps counting in wait.
- R4: With control bit 5 at 1, the counter holds while the freeze input is high. With bit 5 at 0, the counter keeps counting in freeze.
- R5: Control bits 3..0 read as 0 whatever is written. Bit 4 is fast clear. The control register is the byte at address 0x02.
- R6: On the clock where the running counter goes from 0xFFFF to 0x0000, the overflow flag (bit 7 of the byte at address 0x03) becomes 1.
- R7: A channel event strobe sets bit n of the channel flag byte at address 0x04. Writing 1 to a flag bit clears it, and writing 0 leaves it. With fast clear at 0, counter reads and channel register accesses clear no flag.
- R8: With fast clear at 1, any read or write of the counter (address 0x00 or 0x01) clears the overflow flag. A counter write never changes the count.
- R9: With fast clear at 1, a read of a capture channel's register (ch_is_cmp[n]=0) clears flag n, and a write of a compare channel's register (ch_is_cmp[n]=1) clears flag n. The opposite access clears nothing.
- R10: A 16-bit read at address 0x00 returns the whole count from one clock. An 8-bit read at 0x00 returns the high byte and latches the low byte, and a later 8-bit read at 0x01 returns the latched low byte.
- R11: When a flag's set event and a clearing access fall on the same clock, the flag ends up set.
- R12: The register of channel n sits at addresses 0x10+2n (high byte) and 0x11+2n (low byte). It stores 16-bit writes and 8-bit writes to either byte, and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit transfer on bits 7..0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| sys_wait | input | 1 | System is in wait mode |
| sys_freeze | input | 1 | System is in freeze mode |
| ch_event | input | 8 | Per-channel flag-set strobe |
| ch_is_cmp | input | 8 | Per-channel kind: 1 = compare, 0 = capture |
| ovf_flag | output | 1 | Overflow flag |
| ch_flag | output | 8 | Channel event flags |

## Verification
The bench builds the block with its default widths: a 16-bit counter and eight channels. At this width a full wrap takes 65536 enabled clocks, so the bench can run the counter through two real wraps. It places a counter access exactly on the wrap clock, which tests both the overflow set and the set-over-clear rule. Eight channels split into four capture and four compare channels, so every fast-clear access can be tried against both kinds.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    typedef struct packed {
        logic en;
        logic swai;
        logic sfrz;
        logic ffca;
    } tmr_ctrl_t;

    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CNT_HI = 5'h00;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 5'h01;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h02;
    localparam logic [ADDR_W-1:0] A_OVF    = 5'h03;
    localparam logic [ADDR_W-1:0] A_CHF    = 5'h04;

endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [7:0] wbyte,
    input  logic      sys_wait,
    input  logic      sys_freeze,
    output tmr_ctrl_t ctrl,
    output logic      run
);

    typedef struct packed {
        tmr_ctrl_t ctrl;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl.en   = wbyte[7];
            st_d.ctrl.swai = wbyte[6];
            st_d.ctrl.sfrz = wbyte[5];
            st_d.ctrl.ffca = wbyte[4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    always_comb begin
        run = st_q.ctrl.en;
        if (sys_wait && st_q.ctrl.swai)   run = 1'b0;
        if (sys_freeze && st_q.ctrl.sfrz) run = 1'b0;
    end

    assert_ctrl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl == tmr_ctrl_t'($past(wbyte[7:4]))));

endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hi_snap,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       lo_hold,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [7:0]       lo;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run)     st_d.cnt = st_q.cnt + 1'b1;
        if (hi_snap) st_d.lo  = st_q.cnt[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign lo_hold = st_q.lo;
    assign wrap    = run && (&st_q.cnt);

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) + 1'b1));

    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    assert_lo_snap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hi_snap |=> (lo_hold == $past(cnt[7:0])));

endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic              ovf_clr,
    input  logic [NUM_CH-1:0] ch_set,
    input  logic [NUM_CH-1:0] ch_clr,
    output logic              ovf,
    output logic [NUM_CH-1:0] chf
);

    typedef struct packed {
        logic              ovf;
        logic [NUM_CH-1:0] chf;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = wrap | (st_q.ovf & ~ovf_clr);
        st_d.chf = ch_set | (st_q.chf & ~ch_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf = st_q.ovf;
    assign chf = st_q.chf;

    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf);

    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !wrap) |=> !ovf);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ch_set[n] |=> chf[n]);
    end

endmodule

// File: rtl/tmr_chan_bank.sv
`timescale 1ns/1ps
module tmr_chan_bank #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       be,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] rd_word
);

    typedef struct packed {
        logic [NUM_CH-1:0][CNT_W-1:0] r;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [NUM_CH-1:0] hit;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
        assign hit[n] = wr_en && (idx == IDX_W'(n));
    end

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NUM_CH; n++) begin
            if (hit[n] && be[1]) st_d.r[n][CNT_W-1:8] = wval[CNT_W-1:8];
            if (hit[n] && be[0]) st_d.r[n][7:0]       = wval[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word = st_q.r[idx];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        assert_chan_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[n] && be[0]) |=> (st_q.r[n][7:0] == $past(wval[7:0])));
    end

endmodule

// File: rtl/frt_timer.sv
`timescale 1ns/1ps
module frt_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              sys_wait,
    input  logic              sys_freeze,
    input  logic [NUM_CH-1:0] ch_event,
    input  logic [NUM_CH-1:0] ch_is_cmp,
    output logic              ovf_flag,
    output logic [NUM_CH-1:0] ch_flag
);

    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    tmr_ctrl_t         ctrl;
    logic              run;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        lo_hold;
    logic              wrap;
    logic [IDX_W-1:0]  ch_idx;
    logic              ch_hit;
    logic              cnt_hit;
    logic              ctrl_we;
    logic              hi_snap;
    logic              ovf_clr;
    logic [NUM_CH-1:0] ch_clr;
    logic [1:0]        ch_be;
    logic [CNT_W-1:0]  ch_wval;
    logic [CNT_W-1:0]  ch_word;
    logic [7:0]        chf_byte;

    function automatic logic [CNT_W-1:0] ext8(input logic [7:0] b);
        return {{(CNT_W-8){1'b0}}, b};
    endfunction

    // Address decode
    always_comb begin
        ch_idx  = bus_addr[IDX_W:1];
        ch_hit  = bus_addr[4] && (32'(ch_idx) < NUM_CH);
        cnt_hit = (bus_addr[4:1] == 4'd0);
        ctrl_we = bus_wr && (bus_addr == A_CTRL);
        hi_snap = bus_rd && !bus_wide && (bus_addr == A_CNT_HI);
        ovf_clr = (ctrl.ffca && (bus_rd || bus_wr) && cnt_hit)
                || (bus_wr && (bus_addr == A_OVF) && bus_wdata[7]);
        if (bus_wide)         ch_be = 2'b11;
        else if (bus_addr[0]) ch_be = 2'b01;
        else                  ch_be = 2'b10;
        ch_wval = bus_wide ? bus_wdata : {2{bus_wdata[7:0]}};
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_clr
        logic wr_one;
        logic fast;
        assign wr_one    = bus_wr && (bus_addr == A_CHF) && bus_wdata[n];
        assign fast      = ctrl.ffca && ch_hit && (ch_idx == IDX_W'(n))
                         && (ch_is_cmp[n] ? bus_wr : bus_rd);
        assign ch_clr[n] = wr_one || fast;
    end

    tmr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_we),
        .wbyte      (bus_wdata[7:0]),
        .sys_wait   (sys_wait),
        .sys_freeze (sys_freeze),
        .ctrl       (ctrl),
        .run        (run)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .hi_snap (hi_snap),
        .cnt     (cnt),
        .lo_hold (lo_hold),
        .wrap    (wrap)
    );

    tmr_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .ovf_clr (ovf_clr),
        .ch_set  (ch_event),
        .ch_clr  (ch_clr),
        .ovf     (ovf_flag),
        .chf     (ch_flag)
    );

    tmr_chan_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && ch_hit),
        .idx     (ch_idx),
        .be      (ch_be),
        .wval    (ch_wval),
        .rd_word (ch_word)
    );

    // Read data
    always_comb begin
        chf_byte             = '0;
        chf_byte[NUM_CH-1:0] = ch_flag;
        bus_rdata            = '0;
        if (bus_rd) begin
            if (ch_hit) begin
                if (bus_wide)         bus_rdata = ch_word;
                else if (bus_addr[0]) bus_rdata = ext8(ch_word[7:0]);
                else                  bus_rdata = ext8(ch_word[CNT_W-1:8]);
            end else begin
                case (bus_addr)
                    A_CNT_HI: bus_rdata = bus_wide ? cnt : ext8(cnt[CNT_W-1:8]);
                    A_CNT_LO: bus_rdata = ext8(lo_hold);
                    A_CTRL:   bus_rdata = ext8({ctrl.en, ctrl.swai, ctrl.sfrz, ctrl.ffca, 4'b0000});
                    A_OVF:    bus_rdata = ext8({ovf_flag, 7'b0});
                    A_CHF:    bus_rdata = ext8(chf_byte);
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_wait && ctrl.swai) |=> $stable(cnt));

    assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_freeze && ctrl.sfrz) |=> $stable(cnt));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        assert_fast_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl.ffca && bus_rd && ch_hit && (ch_idx == IDX_W'(n))
             && !ch_is_cmp[n] && !ch_event[n]) |=> !ch_flag[n]);
    end

endmodule

// File: tb/frt_timer_tb.sv
`timescale 1ns/1ps
module frt_timer_tb;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sys_wait = 1'b0;
    logic        sys_freeze = 1'b0;
    logic [7:0]  ch_event = '0;
    logic [7:0]  ch_is_cmp = 8'hF0;
    logic        ovf_flag;
    logic [7:0]  ch_flag;

    int errors = 0;
    int checks = 0;
    logic [15:0] a, b, v;

    always #2.5 clk = ~clk;

    frt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sys_wait(sys_wait), .sys_freeze(sys_freeze),
        .ch_event(ch_event), .ch_is_cmp(ch_is_cmp), .ovf_flag(ovf_flag),
        .ch_flag(ch_flag)
    );

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [4:0] ad, input logic wide, output logic [15:0] d);
        @(negedge clk);
        bus_addr = ad; bus_wide = wide; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [4:0] ad, input logic wide, input logic [15:0] d);
        @(negedge clk);
        bus_addr = ad; bus_wide = wide; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(posedge clk);
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        ch_event = m;
        @(posedge clk);
        #1 ch_event = '0;
    endtask

    // event strobe and bus access on the same clock
    task automatic ev_with_access(input logic [7:0] m, input logic [4:0] ad,
                                  input logic is_wr, input logic [15:0] d);
        @(negedge clk);
        ch_event = m; bus_addr = ad; bus_wide = 1'b0; bus_wdata = d;
        bus_rd = !is_wr; bus_wr = is_wr;
        @(posedge clk);
        #1 begin ch_event = '0; bus_rd = 1'b0; bus_wr = 1'b0; end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        bus_read(A_CTRL, 1'b0, d);   check_eq("R2 ctrl after reset", d, 16'h0000);
        bus_read(A_CNT_HI, 1'b1, d); check_eq("R2 count after reset", d, 16'h0000);
        bus_read(A_OVF, 1'b0, d);    check_eq("R2 ovf after reset", d, 16'h0000);
        bus_read(A_CHF, 1'b0, d);    check_eq("R2 chf after reset", d, 16'h0000);
        idle(3);
        bus_read(A_CNT_HI, 1'b1, d); check_eq("R2 count stays stopped", d, 16'h0000);
    endtask

    task automatic t_ctrl_bits;
        logic [15:0] d;
        bus_write(A_CTRL, 1'b0, 16'h000F);
        bus_read(A_CTRL, 1'b0, d);   check_eq("R5 low bits read zero", d, 16'h0000);
        bus_read(A_CNT_HI, 1'b1, a); idle(3); bus_read(A_CNT_HI, 1'b1, b);
        check_eq("R1 disabled counter holds", b - a, 16'd0);
        bus_write(A_CTRL, 1'b0, 16'h00FF);
        bus_read(A_CTRL, 1'b0, d);   check_eq("R5 only upper bits stick", d, 16'h00F0);
        bus_write(A_CTRL, 1'b0, 16'h0080);
        bus_read(A_CNT_HI, 1'b1, a); idle(4); bus_read(A_CNT_HI, 1'b1, b);
        check_eq("R1 enabled counter steps once per clock", b - a, 16'd5);
    endtask

    task automatic mode_case(input string tag, input logic [7:0] ctl,
                             input logic w, input logic f, input logic [15:0] exp);
        bus_write(A_CTRL, 1'b0, {8'h00, ctl});
        sys_wait = w; sys_freeze = f;
        bus_read(A_CNT_HI, 1'b1, a); idle(3); bus_read(A_CNT_HI, 1'b1, b);
        check_eq(tag, b - a, exp);
        sys_wait = 1'b0; sys_freeze = 1'b0;
    endtask

    task automatic t_modes;
        mode_case("R3 wait without stop bit counts", 8'h80, 1'b1, 1'b0, 16'd4);
        mode_case("R3 wait with stop bit holds",     8'hC0, 1'b1, 1'b0, 16'd0);
        mode_case("R3 stop bit outside wait counts", 8'hC0, 1'b0, 1'b0, 16'd4);
        mode_case("R4 freeze without stop bit counts", 8'hC0, 1'b0, 1'b1, 16'd4);
        mode_case("R4 freeze with stop bit holds",   8'hA0, 1'b0, 1'b1, 16'd0);
        mode_case("R4 stop bit outside freeze counts", 8'hA0, 1'b1, 1'b0, 16'd4);
        bus_write(A_CTRL, 1'b0, 16'h0080);
    endtask

    task automatic t_coherent;
        logic [15:0] h, l;
        bus_read(A_CNT_HI, 1'b1, v);
        bus_read(A_CNT_HI, 1'b0, h);
        check_eq("R10 high byte read", h, {8'h00, 8'((v + 16'd1) >> 8)});
        idle(5);
        bus_read(A_CNT_LO, 1'b0, l);
        check_eq("R10 low byte from latch", l, {8'h00, 8'(v + 16'd1)});
    endtask

    task automatic t_channels;
        logic [15:0] d;
        pulse(8'hFF);
        bus_read(A_CHF, 1'b0, d);   check_eq("R7 event strobes set flags", d, 16'h00FF);
        bus_write(5'h16, 1'b1, 16'hBEEF);
        bus_read(5'h16, 1'b1, d);   check_eq("R12 wide store ch3", d, 16'hBEEF);
        bus_write(5'h17, 1'b0, 16'h0011);
        bus_read(5'h16, 1'b1, d);   check_eq("R12 low byte store ch3", d, 16'hBE11);
        bus_read(5'h16, 1'b0, d);   check_eq("R12 high byte read ch3", d, 16'h00BE);
        bus_read(5'h10, 1'b1, d);
        bus_read(A_CHF, 1'b0, d);   check_eq("R7 no fast clear when off", d, 16'h00FF);
        bus_write(A_CHF, 1'b0, 16'h0000);
        bus_read(A_CHF, 1'b0, d);   check_eq("R7 writing zero keeps flags", d, 16'h00FF);
        bus_write(A_CHF, 1'b0, 16'h0001);
        bus_read(A_CHF, 1'b0, d);   check_eq("R7 writing one clears flag", d, 16'h00FE);
        bus_write(A_CTRL, 1'b0, 16'h0090);
        bus_read(5'h12, 1'b1, d);
        bus_read(A_CHF, 1'b0, d);   check_eq("R9 capture read clears", d, 16'h00FC);
        bus_read(5'h1A, 1'b1, d);
        bus_read(A_CHF, 1'b0, d);   check_eq("R9 compare read keeps", d, 16'h00FC);
        bus_write(5'h1A, 1'b1, 16'h5555);
        bus_read(A_CHF, 1'b0, d);   check_eq("R9 compare write clears", d, 16'h00DC);
        bus_write(5'h14, 1'b1, 16'h2222);
        bus_read(A_CHF, 1'b0, d);   check_eq("R9 capture write keeps", d, 16'h00DC);
        bus_read(5'h1A, 1'b1, d);   check_eq("R12 ch5 read back", d, 16'h5555);
        pulse(8'h01);
        ev_with_access(8'h01, A_CHF, 1'b1, 16'h0001);
        bus_read(A_CHF, 1'b0, d);   check_eq("R11 set beats write-one clear", d, 16'h00DD);
        ev_with_access(8'h02, 5'h12, 1'b0, 16'h0000);
        bus_read(A_CHF, 1'b0, d);   check_eq("R11 set beats fast read clear", d, 16'h00DF);
        bus_write(A_CTRL, 1'b0, 16'h0080);
    endtask

    task automatic t_wrap_one;
        logic [15:0] d;
        int n;
        bus_read(A_CNT_HI, 1'b1, a);
        n = 32'h10000 - int'(a);
        idle(n - 2);
        bus_read(A_CNT_HI, 1'b1, d); check_eq("R6 count at top", d, 16'hFFFF);
        bus_read(A_OVF, 1'b0, d);    check_eq("R6 flag set on wrap", d, 16'h0080);
        bus_read(A_CNT_HI, 1'b1, d); check_eq("R6 count restarts", d, 16'h0001);
        bus_read(A_OVF, 1'b0, d);    check_eq("R7 counter read keeps flag", d, 16'h0080);
        bus_write(A_OVF, 1'b0, 16'h0000);
        bus_read(A_OVF, 1'b0, d);    check_eq("R7 writing zero keeps ovf", d, 16'h0080);
        bus_write(A_CTRL, 1'b0, 16'h0090);
        bus_read(A_CNT_HI, 1'b1, v);
        bus_write(A_CNT_HI, 1'b1, 16'h1234);
        bus_read(A_OVF, 1'b0, d);    check_eq("R8 counter write clears ovf", d, 16'h0000);
        bus_read(A_CNT_HI, 1'b1, d); check_eq("R8 write leaves count", d, v + 16'd3);
    endtask

    task automatic t_wrap_two;
        logic [15:0] d;
        int n;
        bus_read(A_CNT_HI, 1'b1, a);
        n = 32'h10000 - int'(a);
        idle(n - 2);
        bus_read(A_CNT_HI, 1'b1, d); check_eq("R6 second top", d, 16'hFFFF);
        bus_read(A_OVF, 1'b0, d);    check_eq("R11 wrap beats fast clear", d, 16'h0080);
        bus_read(A_CNT_HI, 1'b1, d); check_eq("R6 second restart", d, 16'h0001);
        bus_read(A_OVF, 1'b0, d);    check_eq("R8 counter read clears ovf", d, 16'h0000);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_bits();
        t_modes();
        t_coherent();
        t_channels();
        t_wrap_one();
        t_wrap_two();
        summary();
        $finish;
    end

endmodule